// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits on the host side of an asynchronous page-mode parallel ROM and turns a synchronous burst request into a timed sequence of device accesses. The user side presents a start word address and a word count through a valid/ready handshake. Each word returned from the ROM comes back on a data bus with a single-cycle valid strobe. On the device side the block drives the address pins and the active-low chip-enable and output-enable strobes, and it samples the data pins.

Device access times are given in nanoseconds and converted at elaboration into whole clock-cycle wait counts. Each word waits either the full random-access time or the much shorter in-page time. The random-access time applies when the upper address bits change: on the first word of a burst, and when a burst steps into a new page. The in-page time applies when only the page-select bits move. The ROM can be strapped for 32-bit or 16-bit words. In the 16-bit case the pin that would otherwise carry data bit 31 becomes an extra low address bit, and the controller drives that pin. After reset the block keeps chip enable high and refuses commands until the power-up delay has run out. After each burst it waits out the bus-float time before it will take the next command.

Top module: `prom_rd_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low and `rom_ce_n` stays high for exactly PWR_C cycles, where PWR_C = max(1, ceil(PWRUP_NS/CLK_NS)). Requests presented in that window are ignored.
- R2: A command is taken on a clock edge where `req_valid` and `req_ready` are both high. Right after that edge `rom_ce_n` and `rom_oe_n` are low and the first word's address is on the pins. While a burst runs, `req_ready` is low and further requests are ignored.
- R3: The first word of every burst is sampled after its address has been on the pins for RAND_C cycles, and `rsp_valid` is high in the cycle that follows.
- R4: Each later word in the same page (same upper address bits) is sampled PAGE_C cycles after its address is driven.
- R5: A word whose upper address bits differ from the previous word's, including a wrap of the address space, waits RAND_C cycles instead of PAGE_C.
- R6: With `mode_wide`=1 (32-bit words), `rom_a` carries the word address bits [AW-1:0], `rom_am1` is 0, a page is 8 words (word address bits [2:0] select within it), and `rsp_data` returns all 32 data pins.
- R7: With `mode_wide`=0 (16-bit words), `rom_am1` carries word address bit 0, `rom_a` carries bits [AW:1], a page is 16 words (bits [3:0] select within it), `rsp_data[15:0]` is data pins 15..0 and `rsp_data[31:16]` is 0. `rom_am1_oe` equals the inverse of `mode_wide` one cycle later.
- R8: `req_len` holds the word count minus one, so 0..255 give bursts of 1..256 words, and exactly that many `rsp_valid` pulses are produced.
- R9: After the last word is sampled, `rom_ce_n` and `rom_oe_n` go high together and `req_ready` returns high only after HIZ_C further cycles.
- R10: Between the accept edge and the final sample, `rom_ce_n` and `rom_oe_n` stay low, and the address pins do not change except on the edge where a word is sampled.
- R11: RAND_C, PAGE_C and HIZ_C equal ceil(T/CLK_NS) for the random-access, page-access and float times, each at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | Static width strap: 1 = 32-bit words, 0 = 16-bit words |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Controller idle and power-up delay elapsed |
| req_addr | input | AW+1 | Start word address (bit AW unused in 32-bit mode) |
| req_len | input | LEN_W | Word count minus one |
| rsp_valid | output | 1 | One-cycle strobe per returned word |
| rsp_data | output | 32 | Returned word |
| rom_a | output | AW | Device address pins |
| rom_am1 | output | 1 | Extra low address bit for 16-bit mode (data bit 31 pin) |
| rom_am1_oe | output | 1 | Drive enable for the data bit 31 pin |
| rom_ce_n | output | 1 | Active-low chip enable |
| rom_oe_n | output | 1 | Active-low output enable |
| rom_dq | input | 32 | Device data pins |

## Verification
With the accept edge counted as cycle 0, the address and enables are due in cycle 1, and the first `rsp_valid` is due in cycle RAND_C+1. Every later word follows its predecessor by PAGE_C cycles, or by RAND_C cycles when it crosses into a new page. `req_ready` rises HIZ_C cycles after the last strobe's sampling edge, and PWR_C cycles after reset release. A behavioural model in the bench moves one step on each rising edge, using the inputs the bench applied just after the previous edge. On each falling edge, when every output has settled, the design's ports are compared with that model. Latency, word count and the ignoring of requests are then checked again, explicitly, around each command.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIZ  = 2'd2
  } ctl_st_t;

  // Whole cycles covering a time in ns, never below one.
  function automatic int cyc_of(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/prom_pwrup.sv
module prom_pwrup #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
      done  <= (cnt_q == CW'(CYC - 1));
    end
  end

  // R1
  pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

endmodule

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R11
  tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/prom_pin_map.sv
module prom_pin_map #(
  parameter int AW = 27
) (
  input  logic [AW:0]   lin,
  input  logic          wide,
  output logic [AW-1:0] pin_a,
  output logic          am1,
  output logic [AW-4:0] tag
);
  always_comb begin
    if (wide) begin
      pin_a = lin[AW-1:0];
      am1   = 1'b0;
      tag   = lin[AW-1:3];
    end else begin
      pin_a = lin[AW:1];
      am1   = lin[0];
      tag   = lin[AW:4];
    end
  end
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_pkg::*;
#(
  parameter int AW        = 27,
  parameter int LEN_W     = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RAND_NS = 105,
  parameter int T_PAGE_NS = 25,
  parameter int T_HIZ_NS  = 20,
  parameter int PWRUP_NS  = 1000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wide,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic [AW-1:0]    rom_a,
  output logic             rom_am1,
  output logic             rom_am1_oe,
  output logic             rom_ce_n,
  output logic             rom_oe_n,
  input  logic [31:0]      rom_dq
);
  localparam int RAND_C = cyc_of(T_RAND_NS, CLK_NS);
  localparam int PAGE_C = cyc_of(T_PAGE_NS, CLK_NS);
  localparam int HIZ_C  = cyc_of(T_HIZ_NS, CLK_NS);
  localparam int PWR_C  = cyc_of(PWRUP_NS, CLK_NS);
  localparam int MAX1   = (RAND_C > PAGE_C) ? RAND_C : PAGE_C;
  localparam int MAXC   = (MAX1 > HIZ_C) ? MAX1 : HIZ_C;
  localparam int TW     = $clog2(MAXC + 1);

  ctl_st_t          st_q;
  logic [AW:0]      lin_q;
  logic [LEN_W-1:0] left_q;
  logic [AW-4:0]    tag_q;
  logic             mode_q;
  logic             pwr_done;

  logic [AW:0]      lin_inc;
  logic [AW-1:0]    req_pin_a, nxt_pin_a;
  logic             req_am1, nxt_am1;
  logic [AW-4:0]    req_tag, nxt_tag;

  logic             t_load, t_exp;
  logic [TW-1:0]    t_val;
  logic             accept;

  prom_pwrup #(.CYC(PWR_C)) u_pwr (
    .clk(clk), .rst(rst), .done(pwr_done)
  );

  assign lin_inc = lin_q + 1'b1;

  prom_pin_map #(.AW(AW)) u_map_req (
    .lin(req_addr), .wide(mode_wide),
    .pin_a(req_pin_a), .am1(req_am1), .tag(req_tag)
  );

  prom_pin_map #(.AW(AW)) u_map_nxt (
    .lin(lin_inc), .wide(mode_q),
    .pin_a(nxt_pin_a), .am1(nxt_am1), .tag(nxt_tag)
  );

  prom_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .expired(t_exp)
  );

  assign req_ready = (st_q == ST_IDLE) && pwr_done;
  assign accept    = req_valid && req_ready;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (st_q)
      ST_IDLE: if (accept) begin
        t_load = 1'b1;
        t_val  = TW'(RAND_C - 1);
      end
      ST_WAIT: if (t_exp) begin
        t_load = 1'b1;
        if (left_q == '0)          t_val = TW'(HIZ_C - 1);
        else if (nxt_tag != tag_q) t_val = TW'(RAND_C - 1);
        else                       t_val = TW'(PAGE_C - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      lin_q      <= '0;
      left_q     <= '0;
      tag_q      <= '0;
      mode_q     <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rom_a      <= '0;
      rom_am1    <= 1'b0;
      rom_am1_oe <= 1'b0;
      rom_ce_n   <= 1'b1;
      rom_oe_n   <= 1'b1;
    end else begin
      rsp_valid  <= 1'b0;
      rom_am1_oe <= !mode_wide;
      case (st_q)
        ST_IDLE: if (accept) begin
          mode_q   <= mode_wide;
          lin_q    <= req_addr;
          left_q   <= req_len;
          tag_q    <= req_tag;
          rom_a    <= req_pin_a;
          rom_am1  <= req_am1;
          rom_ce_n <= 1'b0;
          rom_oe_n <= 1'b0;
          st_q     <= ST_WAIT;
        end
        ST_WAIT: if (t_exp) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mode_q ? rom_dq : {16'h0000, rom_dq[15:0]};
          if (left_q == '0) begin
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            st_q     <= ST_HIZ;
          end else begin
            lin_q   <= lin_inc;
            left_q  <= left_q - 1'b1;
            tag_q   <= nxt_tag;
            rom_a   <= nxt_pin_a;
            rom_am1 <= nxt_am1;
          end
        end
        ST_HIZ: if (t_exp) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  pwr_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_done |-> (rom_ce_n && !req_ready));

  // R2
  accept_drive_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!rom_ce_n && !rom_oe_n && !req_ready));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !t_exp) |=>
      ($stable(rom_a) && $stable(rom_am1) && !rom_ce_n && !rom_oe_n));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> (rom_ce_n && rom_oe_n && !rsp_valid));

  // R10
  oe_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n);

endmodule

// File: tb/prom_rd_ctrl_tb.sv
module prom_rd_ctrl_tb;
  localparam int AW = 12;
  // Expected counts at a 4 ns clock: 105 ns -> 27, 25 ns -> 7, 20 ns -> 5, 400 ns -> 100
  localparam int RAND_C = 27;
  localparam int PAGE_C = 7;
  localparam int HIZ_C  = 5;
  localparam int PWR_C  = 100;
  localparam int LMASK  = (1 << (AW + 1)) - 1;
  localparam int AMASK  = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wide = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic [AW-1:0] rom_a;
  logic rom_am1, rom_am1_oe, rom_ce_n, rom_oe_n;
  logic [31:0] rom_dq;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] romfn(input int a, input bit am1);
    logic [11:0] a12;
    a12 = 12'(a);
    return {4'hC, a12, 3'b101, am1, a12};
  endfunction

  assign rom_dq = romfn(int'(rom_a), rom_am1);

  prom_rd_ctrl #(
    .AW(AW), .LEN_W(8), .CLK_NS(4),
    .T_RAND_NS(105), .T_PAGE_NS(25), .T_HIZ_NS(20), .PWRUP_NS(400)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_wide(mode_wide),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_a(rom_a), .rom_am1(rom_am1), .rom_am1_oe(rom_am1_oe),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_dq(rom_dq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_st = 0;      // 0 idle, 1 waiting for a word, 2 bus float
  int m_cnt = 0, m_lin = 0, m_left = 0, m_tag = 0, m_pwr = 0;
  bit m_mode = 1'b1;
  string m_kind = "R3";
  bit e_ce_n = 1, e_oe_n = 1, e_rv = 0, e_am1 = 0, e_am1_oe = 0;
  int e_a = 0;
  logic [31:0] e_d = '0;

  function automatic int pa(input int lin, input bit wide);
    return wide ? (lin & AMASK) : ((lin >> 1) & AMASK);
  endfunction
  function automatic bit pm1(input int lin, input bit wide);
    return wide ? 1'b0 : 1'(lin & 1);
  endfunction
  function automatic int ptag(input int lin, input bit wide);
    return wide ? ((lin & AMASK) >> 3) : ((lin & LMASK) >> 4);
  endfunction

  always @(negedge clk) begin
    bit rdy;
    string rq;
    rdy = (m_st == 0) && (m_pwr >= PWR_C);
    rq  = m_mode ? "R6" : "R7";
    chk(req_ready == rdy, (m_pwr >= PWR_C) ? "R9" : "R1", 32'(req_ready), 32'(rdy));
    chk(rom_ce_n == e_ce_n, "R10", 32'(rom_ce_n), 32'(e_ce_n));
    chk(rom_oe_n == e_oe_n, "R10", 32'(rom_oe_n), 32'(e_oe_n));
    chk(rsp_valid == e_rv, m_kind, 32'(rsp_valid), 32'(e_rv));
    if (e_rv) chk(rsp_data == e_d, rq, rsp_data, e_d);
    chk(int'(rom_a) == e_a, rq, 32'(rom_a), 32'(e_a));
    chk(rom_am1 == e_am1, "R7", 32'(rom_am1), 32'(e_am1));
    chk(rom_am1_oe == e_am1_oe, "R7", 32'(rom_am1_oe), 32'(e_am1_oe));
    if (rsp_valid) pulses++;

    // advance the model to the state after the coming rising edge
    if (rst) begin
      m_st = 0; m_cnt = 0; m_lin = 0; m_left = 0; m_tag = 0; m_pwr = 0;
      m_mode = 1'b1; e_ce_n = 1; e_oe_n = 1; e_rv = 0; e_a = 0; e_am1 = 0;
      e_am1_oe = 0; e_d = '0;
    end else begin
      e_rv = 0;
      e_am1_oe = !mode_wide;
      case (m_st)
        0: if (req_valid && rdy) begin
          m_mode = mode_wide; m_lin = int'(req_addr); m_left = int'(req_len);
          m_tag = ptag(m_lin, m_mode); e_a = pa(m_lin, m_mode);
          e_am1 = pm1(m_lin, m_mode); e_ce_n = 0; e_oe_n = 0;
          m_cnt = RAND_C - 1; m_st = 1; m_kind = "R3";
        end
        1: if (m_cnt == 0) begin
          e_rv = 1;
          e_d = romfn(e_a, e_am1);
          if (!m_mode) e_d[31:16] = 16'h0000;
          if (m_left == 0) begin
            e_ce_n = 1; e_oe_n = 1; m_cnt = HIZ_C - 1; m_st = 2;
          end else begin
            int nt;
            m_lin = (m_lin + 1) & LMASK;
            nt = ptag(m_lin, m_mode);
            if (nt != m_tag) begin m_cnt = RAND_C - 1; m_kind = "R5"; end
            else begin m_cnt = PAGE_C - 1; m_kind = "R4"; end
            m_tag = nt; m_left--;
            e_a = pa(m_lin, m_mode); e_am1 = pm1(m_lin, m_mode);
          end
        end else m_cnt--;
        default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
      if (m_pwr < PWR_C) m_pwr++;
    end
  end

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary_and_end();
    end
  end

  task automatic run_cmd(input int addr, input int len_m1, input bit wide);
    int lat;
    @(posedge clk); #1;
    mode_wide = wide;
    req_addr  = (AW+1)'(addr);
    req_len   = 8'(len_m1);
    req_valid = 1'b1;
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;             // accept edge
    pulses   = 0;
    req_addr = 13'h0AAA;            // held valid: must be ignored while busy (R2)
    req_len  = 8'h33;
    chk(rom_ce_n == 1'b0 && rom_oe_n == 1'b0, "R2", {30'd0, rom_ce_n, rom_oe_n}, 32'd0);
    chk(req_ready == 1'b0, "R2", 32'(req_ready), 32'd0);
    lat = 1;
    while (!rsp_valid && lat < 400) begin
      @(posedge clk); #1; lat++;
      if (lat == 15) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(lat == RAND_C + 1, "R11", 32'(lat), 32'(RAND_C + 1));
    while (!req_ready) begin @(posedge clk); #1; end
    chk(pulses == len_m1 + 1, "R8", 32'(pulses), 32'(len_m1 + 1));
  endtask

  initial begin
    int lat;
    req_valid = 1'b1;               // request during power-up: ignored (R1)
    req_addr  = 13'd3;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(req_ready == 1'b0 && rom_ce_n == 1'b1, "R1", {30'd0, req_ready, rom_ce_n}, 32'd1);
    lat = 0;
    while (!req_ready && lat < 1000) begin
      @(posedge clk); #1; lat++;
      if (lat == 50) req_valid = 1'b0;
    end
    chk(lat == PWR_C, "R1", 32'(lat), 32'(PWR_C));
    chk(rom_ce_n == 1'b1, "R1", 32'(rom_ce_n), 32'd1);

    run_cmd(5, 0, 1'b1);            // single word, 32-bit
    run_cmd(5, 9, 1'b1);            // crosses page at word 8 (R5)
    run_cmd(4094, 3, 1'b1);         // wrap of address space (R5)
    run_cmd(0, 255, 1'b1);          // longest burst (R8)
    run_cmd(13, 19, 1'b0);          // 16-bit, crosses 16 and 32 (R7)
    run_cmd(7, 0, 1'b0);            // 16-bit odd address single word
    run_cmd(8190, 2, 1'b0);         // 16-bit wrap
    repeat (10) @(posedge clk);
    #1;
    summary_and_end();
  end

endmodule